// File: doc/BRIEF.md
# Amplifier Offset Trim Calibration Sequencer

This block runs the input-offset calibration of one amplifier channel in hardware. After a start request it holds the amplifier in calibration mode and works through four passes, one for each combination of speed mode and input differential pair. In each pass it selects the matching speed setting and comparison reference. It then walks a 5-bit trim code upward from zero. After every trim change it waits a programmable number of clock cycles so that the analog comparator can settle, and only then samples the comparator.

A pass ends at the first trim code for which the comparator reads 0. That code is kept on the output that belongs to the pass. Any pass can be masked off when its mode is never used. If the comparator never falls, the pass stores the top code and raises a sticky error flag. When the last pass is over, calibration mode is released and a one-cycle done pulse is issued. The surrounding logic feeds the stored codes to the amplifier's user trim inputs.

Top module: `trim_cal_seq`

## Requirements
- R1: Passes run in a fixed order, indexed 0 to 3: normal-speed N pair, normal-speed P pair, high-speed N pair, high-speed P pair. `high_speed_o` is 0 during passes 0 and 1 and 1 during passes 2 and 3. Mode and reference stay constant within a pass.
- R2: While `cal_on_o` is high, `ref_sel_o` is 2'b11 in an N-pair pass (passes 0 and 2) and 2'b01 in a P-pair pass (passes 1 and 3).
- R3: An accepted start sets `user_trim_o`, which then stays at 1 until reset. `cal_on_o` is high from the cycle after the accepted start until the last pass ends.
- R4: Every pass starts with `trim_o` at 0. Within a pass, `trim_o` only ever rises by exactly 1.
- R5: Each trim code is held for `settle_cycles_i`+1 cycles, and the comparator is sampled only in the last of them. From the start edge to the first cycle with `done_o` high takes 2 + Σ over passes (1 cycle if the pass is skipped, otherwise 1 + (c+1)(S+1) cycles) edges, where c is the stored code and S is the settle count.
- R6: A pass stops at the first code whose comparator sample is 0 and stores that code on its output: `norm_n_code_o`, `norm_p_code_o`, `fast_n_code_o` or `fast_p_code_o`.
- R7: When bit i of `skip_i` is 1, pass i is skipped. It takes one cycle, and its code output keeps its previous value.
- R8: If the comparator still reads 1 at code 31, the pass stores 31 and sets `err_o`. `err_o` stays set until the next accepted start clears it.
- R9: `done_o` is high for exactly one cycle, with `cal_on_o` low, and the block then returns to idle with `busy_o` low.
- R10: A start request while `busy_o` is high is ignored. It changes neither the timing nor the results of the run in progress.
- R11: After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, accepted only when idle |
| skip_i | input | 4 | Per-pass skip mask, bit i for pass i |
| settle_cycles_i | input | SETTLE_W | Settle wait, in cycles, after each trim change |
| cmp_i | input | 1 | Calibration comparator output |
| cal_on_o | output | 1 | Amplifier calibration mode request |
| high_speed_o | output | 1 | Speed mode of the current pass |
| ref_sel_o | output | 2 | Reference select of the current pass |
| user_trim_o | output | 1 | Use user trim codes instead of factory ones |
| trim_o | output | TRIM_W | Trim code under test |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Sticky: a pass reached code 31 without the comparator falling |
| norm_n_code_o | output | TRIM_W | Stored code, normal speed, N pair |
| norm_p_code_o | output | TRIM_W | Stored code, normal speed, P pair |
| fast_n_code_o | output | TRIM_W | Stored code, high speed, N pair |
| fast_p_code_o | output | TRIM_W | Stored code, high speed, P pair |

## Verification
Some properties are checked on every cycle:
- the trim code only rises by one, and only after the settle timer has expired;
- mode and reference stay stable within a pass, and the reference is always legal while calibrating;
- user trim is asserted during calibration;
- the done pulse is a single cycle with calibration released;
- the error flag stays set while busy;
- the sequencer stays busy across an ignored start.

Other behaviours can only be shown by the bench scenarios, because they need a comparator model and stored state across runs:
- the order of the passes and the stored code for each target;
- keeping old codes in skipped passes;
- the end-to-end latency formula;
- the saturation at 31.

// File: rtl/trim_cal_pkg.sv
package trim_cal_pkg;
  localparam int NUM_PASSES = 4;
  localparam int IDX_W      = 2;
  localparam logic [1:0] REF_N = 2'b11;
  localparam logic [1:0] REF_P = 2'b01;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_PICK   = 2'd1,
    ST_WAIT   = 2'd2,
    ST_FINISH = 2'd3
  } seq_state_t;

  // Passes 2 and 3 run the amplifier in high-speed mode.
  function automatic logic pass_fast(input logic [IDX_W-1:0] idx);
    return idx[1];
  endfunction

  // Odd passes calibrate the P pair, even passes the N pair.
  function automatic logic [1:0] pass_ref(input logic [IDX_W-1:0] idx);
    return idx[0] ? REF_P : REF_N;
  endfunction
endpackage

// File: rtl/cal_settle_timer.sv
module cal_settle_timer #(
  parameter int CNT_W = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (load)         cnt_q <= load_val;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/cal_trim_counter.sv
module cal_trim_counter #(
  parameter int TRIM_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              step,
  output logic [TRIM_W-1:0] trim,
  output logic              at_max
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     trim <= '0;
    else if (clear) trim <= '0;
    else if (step)  trim <= trim + 1'b1;
  end

  assign at_max = &trim;
endmodule

// File: rtl/cal_code_bank.sv
module cal_code_bank #(
  parameter int TRIM_W = 5,
  parameter int PASSES = 4,
  localparam int SEL_W = (PASSES > 1) ? $clog2(PASSES) : 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [SEL_W-1:0]              wr_sel,
  input  logic [TRIM_W-1:0]             wr_code,
  output logic [PASSES-1:0][TRIM_W-1:0] codes
);
  for (genvar g = 0; g < PASSES; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   codes[g] <= '0;
      else if (wr_en && (wr_sel == SEL_W'(g)))      codes[g] <= wr_code;
    end
  end
endmodule

// File: rtl/trim_cal_seq.sv
module trim_cal_seq
  import trim_cal_pkg::*;
#(
  parameter int TRIM_W   = 5,
  parameter int SETTLE_W = 17
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic [3:0]          skip_i,
  input  logic [SETTLE_W-1:0] settle_cycles_i,
  input  logic                cmp_i,
  output logic                cal_on_o,
  output logic                high_speed_o,
  output logic [1:0]          ref_sel_o,
  output logic                user_trim_o,
  output logic [TRIM_W-1:0]   trim_o,
  output logic                busy_o,
  output logic                done_o,
  output logic                err_o,
  output logic [TRIM_W-1:0]   norm_n_code_o,
  output logic [TRIM_W-1:0]   norm_p_code_o,
  output logic [TRIM_W-1:0]   fast_n_code_o,
  output logic [TRIM_W-1:0]   fast_p_code_o
);
  localparam int PIDX_W = IDX_W + 1;

  seq_state_t               state_q;
  logic [PIDX_W-1:0]        pass_q;
  logic [IDX_W-1:0]         pidx;
  logic                     all_passed;
  logic                     settle_done;
  logic                     at_max;
  logic                     timer_load;
  logic                     trim_clear;
  logic                     step_ev;
  logic                     pass_end;
  logic                     pass_fail;
  logic                     err_q;
  logic                     user_trim_q;
  logic [NUM_PASSES-1:0][TRIM_W-1:0] codes;

  assign pidx       = pass_q[IDX_W-1:0];
  assign all_passed = (pass_q == PIDX_W'(NUM_PASSES));

  // Named events within a waiting pass
  assign pass_end  = (state_q == ST_WAIT) && settle_done && (!cmp_i || at_max);
  assign pass_fail = pass_end && cmp_i;
  assign step_ev   = (state_q == ST_WAIT) && settle_done && cmp_i && !at_max;

  assign trim_clear = ((state_q == ST_PICK) && !all_passed && !skip_i[pidx]) || pass_end;
  assign timer_load = ((state_q == ST_PICK) && !all_passed && !skip_i[pidx]) || step_ev;

  cal_settle_timer #(.CNT_W(SETTLE_W)) i_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (timer_load),
    .load_val (settle_cycles_i),
    .expired  (settle_done)
  );

  cal_trim_counter #(.TRIM_W(TRIM_W)) i_trim (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (trim_clear),
    .step   (step_ev),
    .trim   (trim_o),
    .at_max (at_max)
  );

  cal_code_bank #(.TRIM_W(TRIM_W), .PASSES(NUM_PASSES)) i_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (pass_end),
    .wr_sel  (pidx),
    .wr_code (trim_o),
    .codes   (codes)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      pass_q      <= '0;
      err_q       <= 1'b0;
      user_trim_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            state_q     <= ST_PICK;
            pass_q      <= '0;
            err_q       <= 1'b0;
            user_trim_q <= 1'b1;
          end
        end
        ST_PICK: begin
          if (all_passed)          state_q <= ST_FINISH;
          else if (skip_i[pidx])   pass_q  <= pass_q + 1'b1;
          else                     state_q <= ST_WAIT;
        end
        ST_WAIT: begin
          if (pass_end) begin
            pass_q  <= pass_q + 1'b1;
            state_q <= ST_PICK;
            if (pass_fail) err_q <= 1'b1;
          end
        end
        ST_FINISH: state_q <= ST_IDLE;
        default:   state_q <= ST_IDLE;
      endcase
    end
  end

  assign cal_on_o      = (state_q == ST_PICK) || (state_q == ST_WAIT);
  assign busy_o        = (state_q != ST_IDLE);
  assign done_o        = (state_q == ST_FINISH);
  assign err_o         = err_q;
  assign user_trim_o   = user_trim_q;
  assign high_speed_o  = cal_on_o && pass_fast(pidx);
  assign ref_sel_o     = cal_on_o ? pass_ref(pidx) : 2'b00;
  assign norm_n_code_o = codes[0];
  assign norm_p_code_o = codes[1];
  assign fast_n_code_o = codes[2];
  assign fast_p_code_o = codes[3];
endmodule

// File: rtl/trim_cal_seq_chk.sv
module trim_cal_seq_chk #(
  parameter int TRIM_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              cal_on_o,
  input logic              high_speed_o,
  input logic [1:0]        ref_sel_o,
  input logic              user_trim_o,
  input logic [TRIM_W-1:0] trim_o,
  input logic              busy_o,
  input logic              done_o,
  input logic              err_o,
  input logic              settle_done
);
  a_r2_ref_legal: assert property (@(posedge clk) disable iff (!rst_n)
    cal_on_o |-> (ref_sel_o == 2'b11 || ref_sel_o == 2'b01));

  a_r3_user_trim_in_cal: assert property (@(posedge clk) disable iff (!rst_n)
    cal_on_o |-> user_trim_o);

  a_r4_trim_step_one: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_on_o && $past(cal_on_o) && trim_o != $past(trim_o) && trim_o != '0)
      |-> trim_o == TRIM_W'($past(trim_o) + 1'b1));

  a_r5_step_after_settle: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_on_o && $past(cal_on_o) && trim_o != $past(trim_o) && trim_o != '0)
      |-> $past(settle_done));

  a_r1_mode_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_on_o && $past(cal_on_o) && trim_o != '0)
      |-> ($stable(ref_sel_o) && $stable(high_speed_o)));

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  a_r9_done_cal_off: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !cal_on_o);

  a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (err_o && busy_o) |=> err_o);

  a_r10_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_on_o && start_i) |=> busy_o);
endmodule

bind trim_cal_seq trim_cal_seq_chk #(.TRIM_W(TRIM_W)) i_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start_i      (start_i),
  .cal_on_o     (cal_on_o),
  .high_speed_o (high_speed_o),
  .ref_sel_o    (ref_sel_o),
  .user_trim_o  (user_trim_o),
  .trim_o       (trim_o),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .err_o        (err_o),
  .settle_done  (settle_done)
);

// File: tb/test_trim_cal_seq.sv
`timescale 1ns/1ps
module test_trim_cal_seq;
  localparam int TW = 5;
  localparam int SW = 17;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic [3:0]    skip_i = '0;
  logic [SW-1:0] settle_cycles_i = '0;
  logic          cmp_i;
  logic          cal_on_o, high_speed_o, user_trim_o, busy_o, done_o, err_o;
  logic [1:0]    ref_sel_o;
  logic [TW-1:0] trim_o, norm_n_code_o, norm_p_code_o, fast_n_code_o, fast_p_code_o;

  int tests = 0;
  int fails = 0;

  always #2 clk = ~clk;

  trim_cal_seq #(.TRIM_W(TW), .SETTLE_W(SW)) i_trim_cal_seq (.*);

  // Comparator model: stays 1 below the pass's target code.
  // A target of 32 or more never falls.
  logic [5:0] tgt [4];
  int         cur_pass;
  always_comb begin
    case ({high_speed_o, ref_sel_o})
      3'b011:  cur_pass = 0;
      3'b001:  cur_pass = 1;
      3'b111:  cur_pass = 2;
      3'b101:  cur_pass = 3;
      default: cur_pass = 0;
    endcase
    cmp_i = cal_on_o ? ({1'b0, trim_o} < tgt[cur_pass]) : 1'b1;
  end

  // skip[35:32] settle[31:24] t0[23:18] t1[17:12] t2[11:6] t3[5:0]
  localparam logic [35:0] VEC [6] = '{
    {4'b0000, 8'd2, 6'd5,  6'd17, 6'd0,  6'd9 },
    {4'b0000, 8'd0, 6'd31, 6'd1,  6'd12, 6'd3 },
    {4'b0101, 8'd3, 6'd40, 6'd7,  6'd40, 6'd20},
    {4'b0000, 8'd1, 6'd32, 6'd4,  6'd2,  6'd32},
    {4'b1111, 8'd5, 6'd1,  6'd1,  6'd1,  6'd1 },
    {4'b0010, 8'd0, 6'd6,  6'd50, 6'd32, 6'd0 }
  };

  int model_code [4] = '{0, 0, 0, 0};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int code_of(input logic [5:0] t);
    return (t > 6'd31) ? 31 : int'(t);
  endfunction

  function automatic int exp_latency(input logic [3:0] sk, input int s);
    int n = 2;
    for (int p = 0; p < 4; p++) begin
      if (sk[p]) n += 1;
      else       n += 1 + (code_of(tgt[p]) + 1) * (s + 1);
    end
    return n;
  endfunction

  function automatic int out_code(input int p);
    case (p)
      0: return int'(norm_n_code_o);
      1: return int'(norm_p_code_o);
      2: return int'(fast_n_code_o);
      default: return int'(fast_p_code_o);
    endcase
  endfunction

  // Runs one sequence; returns edge count from the start edge to done.
  task automatic run(input logic [3:0] sk, input int s, input bit restart,
                     output int n, output bit cal_mid, output logic [2:0] mode_first);
    @(negedge clk);
    skip_i = sk;
    settle_cycles_i = SW'(s);
    start_i = 1'b1;
    @(posedge clk);
    n = 1;
    #1 start_i = 1'b0;
    cal_mid = cal_on_o;
    mode_first = 3'b000;
    while (!done_o && n < 20000) begin
      @(posedge clk);
      n++;
      #1;
      if (n == 2) mode_first = {high_speed_o, ref_sel_o};
      start_i = (restart && n == 6);
    end
    start_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int n;
    bit cm;
    logic [2:0] mf;
    bit eerr;
    for (int p = 0; p < 4; p++) tgt[p] = 6'd1;

    // R11: reset state
    repeat (3) @(posedge clk);
    #1;
    chk({cal_on_o, high_speed_o, ref_sel_o, user_trim_o, trim_o, busy_o, done_o, err_o} == '0,
        "R11 control outputs after reset", int'(busy_o), 0);
    chk({norm_n_code_o, norm_p_code_o, fast_n_code_o, fast_p_code_o} == '0,
        "R11 codes after reset", int'(norm_n_code_o), 0);
    rst_n = 1'b1;

    // Table walk
    for (int v = 0; v < 6; v++) begin
      logic [3:0] sk;
      int s;
      sk = VEC[v][35:32];
      s  = int'(VEC[v][31:24]);
      tgt[0] = VEC[v][23:18];
      tgt[1] = VEC[v][17:12];
      tgt[2] = VEC[v][11:6];
      tgt[3] = VEC[v][5:0];
      eerr = 1'b0;
      for (int p = 0; p < 4; p++)
        if (!sk[p]) begin
          model_code[p] = code_of(tgt[p]);
          if (tgt[p] > 6'd31) eerr = 1'b1;
        end
      run(sk, s, (v == 0), n, cm, mf);
      chk(n == exp_latency(sk, s), "R5/R10 latency start to done", n, exp_latency(sk, s));
      for (int p = 0; p < 4; p++)
        chk(out_code(p) == model_code[p], "R1/R6/R7 stored code", out_code(p), model_code[p]);
      chk(err_o == eerr, "R8 error flag", int'(err_o), int'(eerr));
      chk(!cal_on_o, "R9 cal_on low with done", int'(cal_on_o), 0);
      if (sk != 4'b1111) chk(cm, "R3 cal_on after start", int'(cm), 1);
      if (!sk[0]) chk(mf == 3'b011, "R2 first pass normal speed ref 11", int'(mf), 3);
      @(posedge clk);
      #1;
      chk(!done_o && !busy_o, "R9 single done pulse then idle", int'(done_o), 0);
      chk(user_trim_o, "R3 user trim kept", int'(user_trim_o), 1);
    end

    // R8: error stays set while idle
    repeat (4) @(posedge clk);
    #1;
    chk(err_o, "R8 error sticky after run", int'(err_o), 1);

    // R4: trim code restarts at 0 for the next pass
    tgt[0] = 6'd3; tgt[1] = 6'd2; tgt[2] = 6'd1; tgt[3] = 6'd1;
    @(negedge clk);
    skip_i = 4'b1100;
    settle_cycles_i = SW'(1);
    start_i = 1'b1;
    @(posedge clk);
    #1 start_i = 1'b0;
    begin
      bit saw_zero_p1 = 1'b0;
      for (int k = 0; k < 40; k++) begin
        @(posedge clk);
        #1;
        if (cal_on_o && ref_sel_o == 2'b01 && trim_o == '0) saw_zero_p1 = 1'b1;
      end
      chk(saw_zero_p1, "R4 second pass starts at code 0", int'(saw_zero_p1), 1);
    end
    chk(norm_n_code_o == 5'd3 && norm_p_code_o == 5'd2, "R4 codes of short run",
        int'(norm_p_code_o), 2);

    // R11: reset clears stored codes
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(norm_n_code_o == '0 && !user_trim_o, "R11 reset clears state", int'(norm_n_code_o), 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule